// File: doc/BRIEF.md
# Per-Port Gamma Lookup Table

This block applies gamma correction to a stream of 8-bit RGB pixels. Each colour channel has its own 256-entry table, and every incoming channel code is replaced by the table entry at that code. Pixels enter and leave through a valid/ready handshake, and the lookup adds one pipeline register.

Software fills the tables through one 32-bit load port. Each load word carries the entry index together with the three channel values, so one write updates the same entry in all three tables. A full table is loaded with 256 writes in ascending index order. A shadow control bit, taken from a configuration write, selects the update policy. With shadowing on, loads go to a hidden bank, and that bank becomes the live one at the next frame-start pulse, so the frame being shown never sees a half-loaded table. With shadowing off, loads change the live table at once.

Top module: `gamma_lut`

## Requirements
- R1: After reset every table holds a linear ramp from 0 to 255, so each channel output equals its input code.
- R2: A load word puts the entry index in bits 31:24, red in bits 23:16, green in bits 15:8 and blue in bits 7:0; one write updates that entry in all three channel tables.
- R3: Red, green and blue are looked up independently, each in its own table at its own input code.
- R4: A configuration write sets the shadow enable from bit 2 of the configuration word and ignores every other bit; after reset, shadowing is off.
- R5: With shadowing off, a load changes the live table, and any pixel accepted in a later cycle sees the new entry.
- R6: With shadowing on, loads do not change the output. After the next frame-start pulse that follows such a load, the banks swap, and pixels accepted from the following cycle see the loaded table.
- R7: A frame-start pulse with no shadowed load since the last swap leaves the live table unchanged.
- R8: A configuration write that clears bit 2 cancels any pending swap, so the hidden bank never goes live.
- R9: A pixel accepted on a clock edge appears at the output one cycle later, with out_valid high. With no accepted pixel and no stalled output, out_valid is low.
- R10: While out_valid is high and out_ready is low, the output data stays stable and in_ready is low.
- R11: A complete 256-write load in ascending index order replaces every entry of all three tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word; bit 2 is the shadow enable |
| lut_we | input | 1 | Table load strobe |
| lut_wdata | input | 32 | Load word: index, red, green, blue |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_r | input | 8 | Input red code |
| in_g | input | 8 | Input green code |
| in_b | input | 8 | Input blue code |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_r | output | 8 | Corrected red |
| out_g | output | 8 | Corrected green |
| out_b | output | 8 | Corrected blue |

## Verification
The assertions check the handshake on every cycle: the one-cycle latency, the absence of spurious valids, and held data under backpressure. They also check the bank-select rules: the live bank changes only on a frame start with a swap pending, and clearing the shadow bit drops the pending swap. The table contents are visible only at the pixel outputs. Ramp reset, field positions, channel independence, immediate versus deferred loads, and the cases where no swap happens are therefore shown by the bench, which sweeps all 256 codes after each load.

// File: rtl/gamma_lut.sv
module gamma_lut #(
  parameter int CW         = 8,
  parameter int SHADOW_BIT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [4*CW-1:0] cfg_wdata,
  input  logic            lut_we,
  input  logic [4*CW-1:0] lut_wdata,
  input  logic            frame_start,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [CW-1:0]   in_r,
  input  logic [CW-1:0]   in_g,
  input  logic [CW-1:0]   in_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [CW-1:0]   out_r,
  output logic [CW-1:0]   out_g,
  output logic [CW-1:0]   out_b
);
  localparam int DEPTH = 1 << CW;
  localparam int NCH   = 3;

  logic shadow_en, live, pending;
  logic [CW-1:0] wr_idx;
  logic [NCH*CW-1:0] pin, pout, wr_val;
  logic wr_bank, accept;
  logic unused_cfg;

  assign unused_cfg = ^cfg_wdata;
  assign wr_idx  = lut_wdata[4*CW-1 -: CW];
  assign wr_val  = lut_wdata[NCH*CW-1:0];
  assign pin     = {in_r, in_g, in_b};
  assign wr_bank = shadow_en ? ~live : live;
  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;
  assign {out_r, out_g, out_b} = pout;

  always_ff @(posedge clk) begin
    if (!rst_n) shadow_en <= 1'b0;
    else if (cfg_we) shadow_en <= cfg_wdata[SHADOW_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                  pending <= 1'b0;
    else if (cfg_we && !cfg_wdata[SHADOW_BIT])   pending <= 1'b0;
    else if (frame_start && pending)             pending <= 1'b0;
    else if (lut_we && shadow_en)                pending <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) live <= 1'b0;
    else if (frame_start && pending) live <= ~live;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    logic [CW-1:0] tbl [2*DEPTH];
    logic [CW-1:0] q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < 2*DEPTH; i++) tbl[i] <= CW'(i);
      end else if (lut_we) begin
        tbl[{wr_bank, wr_idx}] <= wr_val[ch*CW +: CW];
      end
    end

    always_ff @(posedge clk) begin
      if (accept) q <= tbl[{live, pin[ch*CW +: CW]}];
    end

    assign pout[ch*CW +: CW] = q;
  end
endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk #(
  parameter int CW         = 8,
  parameter int SHADOW_BIT = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [4*CW-1:0] cfg_wdata,
  input logic            frame_start,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [CW-1:0]   out_r,
  input logic [CW-1:0]   out_g,
  input logic [CW-1:0]   out_b,
  input logic            live,
  input logic            pending
);
  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) && !(out_valid && !out_ready) |=> !out_valid); // R9
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b)); // R10
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(live)); // R6
  AST_SWAP_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && pending |=> live != $past(live)); // R6
  AST_NO_IDLE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !pending |=> $stable(live)); // R7
  AST_CANCEL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_wdata[SHADOW_BIT] |=> !pending); // R8
endmodule

bind gamma_lut gamma_lut_chk #(.CW(CW), .SHADOW_BIT(SHADOW_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .frame_start(frame_start), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_r(out_r), .out_g(out_g), .out_b(out_b),
  .live(live), .pending(pending)
);

// File: tb/gamma_lut_tb.sv
module gamma_lut_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, lut_we = 1'b0, frame_start = 1'b0;
  logic [31:0] cfg_wdata = '0, lut_wdata = '0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [7:0] in_r = '0, in_g = '0, in_b = '0;
  logic in_ready, out_valid;
  logic [7:0] out_r, out_g, out_b;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gamma_lut u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .lut_we(lut_we), .lut_wdata(lut_wdata), .frame_start(frame_start),
    .in_valid(in_valid), .in_ready(in_ready), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  // table patterns: 0 ramp, 1..3 loaded patterns; ch 0 red, 1 green, 2 blue
  function automatic logic [7:0] fv(int t, int ch, int i);
    logic [7:0] b;
    b = i[7:0];
    case (t)
      1: case (ch) 0: return ~b; 1: return b + 8'd37; default: return {b[3:0], b[7:4]}; endcase
      2: case (ch) 0: return b * 8'd3; 1: return ~b + 8'd5; default: return b ^ 8'hA5; endcase
      3: case (ch) 0: return 8'h11; 1: return b >> 1; default: return 8'hFF; endcase
      default: return b;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [31:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic lut_write(logic [7:0] idx, logic [7:0] r, logic [7:0] g, logic [7:0] b);
    @(negedge clk); lut_we = 1'b1; lut_wdata = {idx, r, g, b};
    @(negedge clk); lut_we = 1'b0;
  endtask

  task automatic load_table(int t);
    for (int i = 0; i < 256; i++) lut_write(8'(i), fv(t, 0, i), fv(t, 1, i), fv(t, 2, i));
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic send(logic [7:0] r, logic [7:0] g, logic [7:0] b,
                      logic [7:0] er, logic [7:0] eg, logic [7:0] eb, string req);
    @(negedge clk); in_r = r; in_g = g; in_b = b; in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid && out_r == er && out_g == eg && out_b == eb, req,
        {7'd0, out_valid, out_r, out_g, out_b}, {8'd1, er, eg, eb});
    in_valid = 1'b0;
  endtask

  task automatic sweep(int t, string req);
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cr, cg, cb;
      cr = 8'(c); cg = 8'(255 - c); cb = 8'(c) ^ 8'h33;
      send(cr, cg, cb, fv(t, 0, cr), fv(t, 1, cg), fv(t, 2, cb), req);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R9 reset handshake", {out_valid, in_ready}, 2'b01);

    sweep(0, "R1 R3 ramp after reset");

    load_table(1);
    sweep(1, "R2 R5 R11 direct full load");

    cfg_write(32'h0000_0004);
    load_table(2);
    sweep(1, "R6 shadowed load hidden");
    pulse_frame();
    sweep(2, "R6 table after frame start");
    pulse_frame();
    sweep(2, "R7 frame start without load");

    load_table(3);
    cfg_write(32'hFFFF_FFFB);
    pulse_frame();
    sweep(2, "R4 R8 cleared shadow cancels swap");

    lut_write(8'd10, 8'h01, 8'h02, 8'h03);
    send(8'd10, 8'd10, 8'd10, 8'h01, 8'h02, 8'h03, "R2 R5 single direct write");
    send(8'd11, 8'd11, 8'd11, fv(2, 0, 11), fv(2, 1, 11), fv(2, 2, 11), "R5 neighbour entry kept");

    // backpressure
    @(negedge clk); out_ready = 1'b0;
    in_r = 8'd5; in_g = 8'd6; in_b = 8'd7; in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid && out_r == fv(2, 0, 5) && out_g == fv(2, 1, 6) && out_b == fv(2, 2, 7),
        "R9 latency one", {out_valid, out_r, out_g, out_b}, {1'b1, fv(2, 0, 5), fv(2, 1, 6), fv(2, 2, 7)});
    in_r = 8'd200; in_g = 8'd201; in_b = 8'd202;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid && !in_ready && out_r == fv(2, 0, 5) && out_g == fv(2, 1, 6) && out_b == fv(2, 2, 7),
          "R10 held under stall", {in_ready, out_valid, out_r, out_g, out_b},
          {1'b0, 1'b1, fv(2, 0, 5), fv(2, 1, 6), fv(2, 2, 7)});
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid && out_r == fv(2, 0, 200) && out_g == fv(2, 1, 201) && out_b == fv(2, 2, 202),
        "R10 release advances", {out_valid, out_r, out_g, out_b},
        {1'b1, fv(2, 0, 200), fv(2, 1, 201), fv(2, 2, 202)});
    in_valid = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R9 no spurious valid", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule